// File: doc/BRIEF.md
# Serial-to-Parallel Output Expander Controller

The block drives a chain of up to three external 8-bit serial-in, parallel-out shift registers. Together they give 24 output pins. Software sets the pins through a small register write port that holds a 24-bit shadow word. The block sends the word to the chain as a serial bit stream on a data pin and a divided shift clock. After the last bit it raises a store strobe, so every external pin updates at the same moment.

Some bit positions can be given to on-chip status sources instead of software. A modem source can own bits 1:0, a first PHY source can own bits 4:2 and a second PHY source can own bits 7:5. Each of these bits has its own enable. A 3-bit mask chooses which 8-bit groups are fitted on the board, and only those groups are shifted. A configuration bit chooses the shift-clock edge on which the external registers sample their data.

The block sends a new frame each time the effective word changes. The effective word is the shadow word with every enabled override bit put in place. A change that arrives while a frame is being sent is held back and goes out in the next frame.

Top module: `sout_expander`

## Requirements
- R1: After reset the shadow word is RST_SHADOW and is taken to be already on the chain. The group mask is RST_GROUPS, all overrides are off and falling-edge sampling is selected. No frame is sent until the effective word changes, busy is low and the shift clock rests high.
- R2: Write-port address 0 writes the shadow word, and reading address 0 returns the last value software wrote, whatever the overrides do. Address 1 holds the configuration: [2:0] group mask, [4:3] modem override enables, [7:5] PHY-1 override enables, [10:8] PHY-2 override enables, [11] rising-edge select. Reading address 2 returns busy in bit 0.
- R3: A frame starts when the effective word differs from the last word sent. Writing a value that leaves the effective word unchanged sends nothing.
- R4: Bits leave the block from the highest enabled group down to the lowest, and most significant bit first inside each group.
- R5: A frame holds 8 bits for each enabled group, and disabled groups are skipped. With the mask at zero no frame starts.
- R6: When modem enable k (k = 0 or 1) is set, cascade bit k takes modem status bit k. A modem status bit whose enable is clear has no effect.
- R7: When PHY-1 enable k is set, cascade bit 2+k takes PHY-1 status bit k. When PHY-2 enable k is set, cascade bit 5+k takes PHY-2 status bit k (k = 0..2).
- R8: A change on an enabled hardware status bit starts a frame without any software write.
- R9: Changes that arrive during a frame do not disturb it. The next frame carries the latest effective word.
- R10: One shift-clock period is DIV system clocks. The clock rests low when rising-edge sampling is selected and high otherwise. Data changes only while the clock is at its resting level, so it is stable at the sampling edge.
- R11: After the last bit the store strobe is high for exactly DIV system clocks. The shift clock rests and the data pin is low for the whole pulse.
- R12: Busy is high from the first bit of a frame until the end of its store pulse, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 24 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 24 | Register read data (combinational) |
| modem_stat | input | 2 | Modem status bits for cascade bits 1:0 |
| phy1_stat | input | 3 | PHY-1 status bits for cascade bits 4:2 |
| phy2_stat | input | 3 | PHY-2 status bits for cascade bits 7:5 |
| sh_data | output | 1 | Serial data to the chain |
| sh_clk | output | 1 | Shift clock to the chain |
| sh_latch | output | 1 | Store strobe to the chain |
| busy | output | 1 | Frame in progress |

## Verification
Some rules are checked by assertions on every cycle. The data pin may move only while the clock rests. The store pulse lasts DIV cycles, with the clock resting and the data pin low. A frame starts only when the effective word differs from the word last sent. An empty group mask never starts a frame. Nothing moves on the pins while the block is idle. The bench scenarios show the rest by rebuilding each frame from the pins: the bit order and frame length for each group mask, how the per-bit overrides merge, and that a hardware source change starts a frame. They also show that changes arriving mid-frame collapse into one follow-up frame holding the newest word, and that the resting level follows the edge selection.

// File: rtl/sox_pkg.sv
package sox_pkg;
  localparam int GW     = 8;
  localparam int NGRP   = 3;
  localparam int NBITS  = GW * NGRP;
  localparam int CNTW   = $clog2(NBITS + 1);

  localparam logic [1:0] ADDR_SHADOW = 2'd0;
  localparam logic [1:0] ADDR_CFG    = 2'd1;
  localparam logic [1:0] ADDR_STAT   = 2'd2;

  typedef struct packed {
    logic       rise;
    logic [2:0] p2;
    logic [2:0] p1;
    logic [1:0] modem;
    logic [2:0] grp;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  // Overlay enabled hardware status bits on the software word.
  function automatic logic [NBITS-1:0] merge_word(
    input logic [NBITS-1:0] sw, input cfg_t c,
    input logic [1:0] m_s, input logic [2:0] a_s, input logic [2:0] b_s);
    logic [NBITS-1:0] w;
    w = sw;
    for (int i = 0; i < 2; i++) if (c.modem[i]) w[i] = m_s[i];
    for (int i = 0; i < 3; i++) begin
      if (c.p1[i]) w[2+i] = a_s[i];
      if (c.p2[i]) w[5+i] = b_s[i];
    end
    return w;
  endfunction

  // Left-align enabled groups, highest group at the top.
  function automatic logic [NBITS-1:0] pack_frame(
    input logic [NBITS-1:0] w, input logic [NGRP-1:0] g);
    logic [NBITS-1:0] r;
    r = '0;
    for (int k = 0; k < NGRP; k++)
      if (g[k]) r = {w[k*GW +: GW], r[NBITS-1:GW]};
    return r;
  endfunction

  function automatic logic [CNTW-1:0] bit_total(input logic [NGRP-1:0] g);
    logic [CNTW-1:0] n;
    n = '0;
    for (int k = 0; k < NGRP; k++) if (g[k]) n = n + CNTW'(GW);
    return n;
  endfunction
endpackage

// File: rtl/sox_regs.sv
module sox_regs
  import sox_pkg::*;
#(
  parameter logic [NBITS-1:0] RST_SHADOW = '1,
  parameter logic [NGRP-1:0]  RST_GROUPS = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [NBITS-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  input  logic             busy_i,
  output logic [NBITS-1:0] rd_data,
  output logic [NBITS-1:0] shadow_o,
  output cfg_t             cfg_o
);
  logic [NBITS-1:0] shadow_q;
  cfg_t             cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= RST_SHADOW;
      cfg_q    <= '{rise: 1'b0, p2: 3'b0, p1: 3'b0, modem: 2'b0, grp: RST_GROUPS};
    end else if (wr_en) begin
      if (wr_addr == ADDR_SHADOW) shadow_q <= wr_data;
      if (wr_addr == ADDR_CFG)    cfg_q    <= cfg_t'(wr_data[CFG_W-1:0]);
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_SHADOW: rd_data = shadow_q;
      ADDR_CFG:    rd_data[CFG_W-1:0] = cfg_q;
      ADDR_STAT:   rd_data[0] = busy_i;
      default:     rd_data = '0;
    endcase
  end

  assign shadow_o = shadow_q;
  assign cfg_o    = cfg_q;

  // R2: a shadow write is visible on the next cycle
  a_r2_shadow_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_SHADOW) |=> shadow_o == $past(wr_data));
endmodule

// File: rtl/sox_serializer.sv
module sox_serializer
  import sox_pkg::*;
#(
  parameter int               DIV      = 4,
  parameter logic [NBITS-1:0] RST_SENT = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] eff_i,
  input  logic [NGRP-1:0]  grp_i,
  input  logic             rise_i,
  output logic             sh_data_o,
  output logic             sh_clk_o,
  output logic             sh_latch_o,
  output logic             busy_o
);
  localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;
  localparam int LW   = $clog2(DIV + 1) + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_LATCH} st_t;

  st_t              state_q;
  logic [PW-1:0]    phase_q;
  logic [CNTW-1:0]  bit_q, nbits_q;
  logic [NBITS-1:0] sr_q, sent_q;
  logic             edge_q;
  logic             phase_end, frame_go, rest_lvl;

  assign phase_end = (phase_q == PW'(DIV - 1));
  assign frame_go  = (state_q == ST_IDLE) && (eff_i != sent_q) && (bit_total(grp_i) != '0);
  assign rest_lvl  = ~edge_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      bit_q   <= '0;
      nbits_q <= '0;
      sr_q    <= '0;
      sent_q  <= RST_SENT;
      edge_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          edge_q  <= rise_i;
          phase_q <= '0;
          if (frame_go) begin
            state_q <= ST_SHIFT;
            sr_q    <= pack_frame(eff_i, grp_i);
            nbits_q <= bit_total(grp_i);
            sent_q  <= eff_i;
            bit_q   <= '0;
          end
        end
        ST_SHIFT: begin
          phase_q <= phase_end ? '0 : phase_q + PW'(1);
          if (phase_end) begin
            sr_q  <= {sr_q[NBITS-2:0], 1'b0};
            bit_q <= bit_q + CNTW'(1);
            if (bit_q == nbits_q - CNTW'(1)) state_q <= ST_LATCH;
          end
        end
        ST_LATCH: begin
          phase_q <= phase_end ? '0 : phase_q + PW'(1);
          if (phase_end) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sh_clk_o   = rest_lvl ^ ((state_q == ST_SHIFT) && (phase_q >= PW'(HALF)));
  assign sh_data_o  = (state_q == ST_SHIFT) && sr_q[NBITS-1];
  assign sh_latch_o = (state_q == ST_LATCH);
  assign busy_o     = (state_q != ST_IDLE);

  // checker-side counter of consecutive strobe cycles
  logic [LW-1:0] lat_run_q;
  always_ff @(posedge clk) begin
    if (!rst_n) lat_run_q <= '0;
    else        lat_run_q <= sh_latch_o ? lat_run_q + LW'(1) : '0;
  end

  // R10: data only moves while the clock rests
  a_r10_data_moves_at_rest: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sh_data_o) |-> sh_clk_o == rest_lvl);
  // R11: clock rests and data is low during the strobe
  a_r11_latch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sh_latch_o |-> (sh_clk_o == rest_lvl) && !sh_data_o);
  // R11: strobe lasts DIV cycles
  a_r11_latch_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sh_latch_o) |-> lat_run_q == LW'(DIV));
  // R3: a frame only begins on a difference from the last sent word
  a_r3_start_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(eff_i != sent_q));
  // R5: an empty mask never starts a frame
  a_r5_empty_mask_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && grp_i == '0) |=> !busy_o);
endmodule

// File: rtl/sout_expander.sv
module sout_expander
  import sox_pkg::*;
#(
  parameter int          DIV        = 4,
  parameter logic [23:0] RST_SHADOW = 24'hFFFFFF,
  parameter logic [2:0]  RST_GROUPS = 3'b111
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [23:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [23:0] rd_data,
  input  logic [1:0]  modem_stat,
  input  logic [2:0]  phy1_stat,
  input  logic [2:0]  phy2_stat,
  output logic        sh_data,
  output logic        sh_clk,
  output logic        sh_latch,
  output logic        busy
);
  logic [NBITS-1:0] shadow_w, eff_w;
  cfg_t             cfg_w;

  sox_regs #(.RST_SHADOW(RST_SHADOW), .RST_GROUPS(RST_GROUPS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .busy_i(busy), .rd_data(rd_data),
    .shadow_o(shadow_w), .cfg_o(cfg_w));

  assign eff_w = merge_word(shadow_w, cfg_w, modem_stat, phy1_stat, phy2_stat);

  sox_serializer #(.DIV(DIV), .RST_SENT(RST_SHADOW)) u_ser (
    .clk(clk), .rst_n(rst_n), .eff_i(eff_w), .grp_i(cfg_w.grp), .rise_i(cfg_w.rise),
    .sh_data_o(sh_data), .sh_clk_o(sh_clk), .sh_latch_o(sh_latch), .busy_o(busy));

  // R12: idle pins stay quiet
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sh_latch && !sh_data);
endmodule

// File: tb/sout_expander_tb.sv
module sout_expander_tb;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [23:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [23:0] rd_data;
  logic [1:0]  modem_stat = '0;
  logic [2:0]  phy1_stat = '0, phy2_stat = '0;
  logic        sh_data, sh_clk, sh_latch, busy;

  always #5 clk = ~clk;

  sout_expander #(.DIV(DIV), .RST_SHADOW(24'hFFFFFF), .RST_GROUPS(3'b111)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .modem_stat(modem_stat),
    .phy1_stat(phy1_stat), .phy2_stat(phy2_stat),
    .sh_data(sh_data), .sh_clk(sh_clk), .sh_latch(sh_latch), .busy(busy));

  int checks = 0, errors = 0;
  logic [23:0] sh_m = 24'hFFFFFF;
  logic [11:0] cfg_m = 12'h007;

  // pin monitor state
  int          frames = 0, ncap = 0, latw = 0, setup_err = 0;
  logic [23:0] cap = '0;
  logic [23:0] fr_bits [16];
  int          fr_len  [16];
  logic        pclk = 1'b1, pdata = 1'b0, plat = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      ncap = 0; cap = '0; latw = 0;
      pclk = sh_clk; pdata = sh_data; plat = sh_latch;
    end else begin
      if (sh_clk != pclk && sh_clk == cfg_m[11]) begin
        cap = {cap[22:0], sh_data};
        ncap++;
        if (sh_data != pdata) setup_err++;
      end
      if (sh_latch && !plat) begin
        fr_bits[frames % 16] = cap;
        fr_len[frames % 16]  = ncap;
        frames++;
        cap = '0; ncap = 0; latw = 0;
      end
      if (sh_latch) latw++;
      pclk = sh_clk; pdata = sh_data; plat = sh_latch;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_eff();
    logic [23:0] w;
    w = sh_m;
    for (int i = 0; i < 2; i++) if (cfg_m[3+i]) w[i] = modem_stat[i];
    for (int i = 0; i < 3; i++) begin
      if (cfg_m[5+i]) w[2+i] = phy1_stat[i];
      if (cfg_m[8+i]) w[5+i] = phy2_stat[i];
    end
    return w;
  endfunction

  task automatic expect_frame(input int idx, input logic [23:0] w, input string req);
    logic [23:0] bits;
    int n;
    bits = '0; n = 0;
    for (int g = 2; g >= 0; g--)
      if (cfg_m[g])
        for (int b = 7; b >= 0; b--) begin
          bits = {bits[22:0], w[g*8+b]};
          n++;
        end
    check(fr_len[idx % 16] == n, {req, " frame length"}, fr_len[idx % 16], n);
    check(fr_bits[idx % 16] == bits, {req, " frame bits"}, fr_bits[idx % 16], bits);
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [23:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    if (a == 2'd0) sh_m = d;
    if (a == 2'd1) cfg_m = d[11:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    int t;
    t = 0;
    repeat (3) @(negedge clk);
    while (busy && t < 5000) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_frames(input int target, input string req);
    int t;
    t = 0;
    while (frames < target && t < 5000) begin @(negedge clk); t++; end
    check(frames >= target, {req, " frame arrived"}, frames, target);
    settle();
  endtask

  task automatic t_reset();
    rd_addr = 2'd0; #1;
    check(rd_data == 24'hFFFFFF, "R1 shadow default", rd_data, 24'hFFFFFF);
    rd_addr = 2'd1; #1;
    check(rd_data == 24'h000007, "R1 config default", rd_data, 24'h000007);
    check(sh_clk == 1'b1, "R1 clock rests high", sh_clk, 1);
    repeat (60) @(negedge clk);
    check(frames == 0 && !busy && !sh_latch, "R1 no frame after reset", frames, 0);
  endtask

  task automatic t_basic();
    int f0;
    f0 = frames;
    write_reg(2'd0, 24'hA53C0F);
    @(negedge clk);
    check(busy == 1'b1, "R12 busy during frame", busy, 1);
    rd_addr = 2'd2; #1;
    check(rd_data == 24'h1, "R2 busy readable", rd_data, 1);
    wait_frames(f0 + 1, "R3");
    expect_frame(f0, 24'hA53C0F, "R4");
    check(latw == DIV, "R11 strobe width", latw, DIV);
    check(!busy, "R12 busy clears", busy, 0);
    check(setup_err == 0, "R10 data stable at sampling edge", setup_err, 0);
  endtask

  task automatic t_same();
    int f0;
    f0 = frames;
    write_reg(2'd0, 24'hA53C0F);
    repeat (150) @(negedge clk);
    check(frames == f0, "R3 unchanged word sends nothing", frames, f0);
  endtask

  task automatic t_groups();
    int f0;
    f0 = frames;
    write_reg(2'd1, 24'h000005);
    repeat (30) @(negedge clk);
    check(frames == f0, "R3 mask write alone leaves word unchanged", frames, f0);
    write_reg(2'd0, 24'h5A7711);
    wait_frames(f0 + 1, "R5");
    expect_frame(f0, 24'h5A7711, "R5 groups 2 and 0");
    write_reg(2'd1, 24'h000000);
    write_reg(2'd0, 24'h123456);
    repeat (150) @(negedge clk);
    check(frames == f0 + 1 && !busy, "R5 empty mask sends nothing", frames, f0 + 1);
    write_reg(2'd1, 24'h000002);
    wait_frames(f0 + 2, "R5");
    expect_frame(f0 + 1, 24'h123456, "R5 middle group only");
  endtask

  task automatic t_modem();
    int f0;
    f0 = frames;
    modem_stat = 2'b01;
    write_reg(2'd1, 24'h000011);  // group 0, modem enable on bit 1
    wait_frames(f0 + 1, "R6");
    expect_frame(f0, exp_eff(), "R6 modem bit 1");
    check(exp_eff() == 24'h123454, "R6 model sanity", exp_eff(), 24'h123454);
    rd_addr = 2'd0; #1;
    check(rd_data == 24'h123456, "R2 shadow reads software value", rd_data, 24'h123456);
    modem_stat = 2'b00;  // bit 0 not enabled
    repeat (150) @(negedge clk);
    check(frames == f0 + 1, "R6 disabled modem bit ignored", frames, f0 + 1);
    modem_stat = 2'b10;
    wait_frames(f0 + 2, "R8");
    expect_frame(f0 + 1, exp_eff(), "R8 modem change starts frame");
  endtask

  task automatic t_phy();
    int f0;
    f0 = frames;
    phy1_stat = 3'b010; phy2_stat = 3'b001;
    write_reg(2'd1, 24'h0001E1);  // group 0, PHY-1 all, PHY-2 bit 0
    wait_frames(f0 + 1, "R7");
    expect_frame(f0, exp_eff(), "R7 phy overrides");
    check(exp_eff() == 24'h12346A, "R7 model sanity", exp_eff(), 24'h12346A);
    phy2_stat = 3'b000;
    wait_frames(f0 + 2, "R8");
    expect_frame(f0 + 1, exp_eff(), "R8 phy change starts frame");
  endtask

  task automatic t_queue();
    int f0;
    write_reg(2'd1, 24'h000007);
    settle();
    f0 = frames;
    write_reg(2'd0, 24'h0F0F0F);
    while (!busy) @(negedge clk);
    write_reg(2'd0, 24'hAAAAAA);
    repeat (10) @(negedge clk);
    write_reg(2'd0, 24'h333333);
    wait_frames(f0 + 2, "R9");
    expect_frame(f0, 24'h0F0F0F, "R9 first frame undisturbed");
    expect_frame(f0 + 1, 24'h333333, "R9 newest word follows");
    repeat (150) @(negedge clk);
    check(frames == f0 + 2, "R9 single follow-up frame", frames, f0 + 2);
  endtask

  task automatic t_rise();
    int f0;
    write_reg(2'd1, 24'h000807);
    settle();
    check(sh_clk == 1'b0, "R10 clock rests low in rising mode", sh_clk, 0);
    f0 = frames;
    write_reg(2'd0, 24'hC0FFEE);
    wait_frames(f0 + 1, "R10");
    expect_frame(f0, 24'hC0FFEE, "R10 rising-edge frame");
    check(setup_err == 0, "R10 data stable at rising edge", setup_err, 0);
    check(sh_clk == 1'b0, "R10 clock back at rest", sh_clk, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_same();
    t_groups();
    t_modem();
    t_phy();
    t_queue();
    t_rise();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule